// File: doc/BRIEF.md
# Systematic Reed-Solomon Encoder

This block turns a stream of message symbols into systematic Reed-Solomon codewords over GF(2^S). Message symbols arrive on a valid/ready input framed by start and end markers. Each symbol is copied to the output unchanged and also fed into a division register that holds the remainder of the message polynomial, scaled by x^NPAR, modulo the generator polynomial. When the end-marked symbol has been taken, the input stalls. The register then shifts its NPAR = 2T remainder symbols out, highest degree first. These parity symbols follow the last message symbol with no gap. The result corrects up to T symbol errors.

The symbol width, the number of correctable errors, the field polynomial and the exponent of the first generator root are elaboration-time parameters. The generator coefficients are computed from these at elaboration. A codeword may carry anywhere from 1 to 2^S-1-NPAR message symbols. A shorter message encodes exactly as if the missing leading symbols were zero, and no padding cycles are spent. The output always trails the accepted input by one register stage, and a new codeword may begin on the cycle after the last parity symbol is produced.

Top module: `rs_sys_encoder`

## Requirements
- R1: While reset is held, and on the first cycle after it, `in_ready` is 1, `out_valid` is 0 and `out_eop` is 0. This also holds when reset arrives in the middle of a parity run.
- R2: A message symbol accepted on a rising edge (`in_valid` and `in_ready` both 1) appears on `out_data` after that same edge, with `out_valid`=1 and `out_parity`=0. `out_sop` is 1 only on the symbol that was accepted with `in_sop`=1.
- R3: After the symbol accepted with `in_eop`=1, exactly NPAR symbols with `out_parity`=1 follow on consecutive cycles. `out_eop` is 1 only on the last of them.
- R4: `in_ready` is 0 on every cycle of a parity run except the one that presents the final parity symbol. Symbols offered on those cycles are neither consumed nor allowed to alter the codeword.
- R5: With alpha the field element x (value 2), the output codeword evaluates to zero at alpha^(B+i) for i = 0..NPAR-1. Here the first output symbol is the highest-degree coefficient and B is `FIRST_ROOT`.
- R6: A message of k symbols yields the same parity as the same message preceded by any number of zero symbols, for any k from 1 to 2^S-1-NPAR.
- R7: A symbol accepted with `in_sop`=1 starts a fresh codeword, discarding any partial remainder left by an unfinished one.
- R8: When the next message is offered at once, its first symbol appears on the output on the cycle right after the final parity symbol.
- R9: A cycle in the message phase with `in_valid`=0 produces `out_valid`=0 and leaves the remainder unchanged.
- R10: The `PRIM` and `FIRST_ROOT` parameters select the field and the generator. With x^8+x^7+x^2+x+1 (`PRIM`='h187), T=3 and first root 1, the codewords meet R5 in that field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Message symbol offered |
| in_ready | output | 1 | Encoder can take a message symbol this cycle |
| in_data | input | S | Message symbol |
| in_sop | input | 1 | Offered symbol is the first of a codeword |
| in_eop | input | 1 | Offered symbol is the last message symbol of a codeword |
| out_valid | output | 1 | Output symbol present |
| out_data | output | S | Codeword symbol |
| out_sop | output | 1 | First symbol of a codeword |
| out_eop | output | 1 | Last parity symbol of a codeword |
| out_parity | output | 1 | Output symbol is a parity symbol |

## Verification
The bench evaluates every captured codeword at all generator roots in a field model of its own. This means any wrong coefficient, a reversed tap order or a misplaced feedback tap shows up as a nonzero syndrome. Several corner cases get their own tests: one-symbol messages, full-length messages, zero-prefixed twins of a shortened message, and a restart marker on an unfinished codeword. A design that padded shortened words, or kept a stale remainder, would produce parity that differs between twins. Symbols are offered during parity runs and codewords are sent back to back. An encoder that accepted input too early would emit extra symbols and corrupt the next remainder, and one that idled between words would leave a one-cycle hole. A reset during a parity run and a second instance built on the other field polynomial complete the set.

// File: rtl/rs_enc_pkg.sv
package rs_enc_pkg;

   typedef enum logic {
      PH_DATA   = 1'b0,
      PH_PARITY = 1'b1
   } rs_phase_e;

   // Product of two field elements; prim includes the x^s term.
   function automatic int gf_mul(input int a, input int b, input int prim, input int s);
      int acc;
      int x;
      acc = 0;
      x   = a;
      for (int i = 0; i < s; i++) begin
         if (((b >> i) & 1) != 0) acc = acc ^ x;
         x = x << 1;
         if (((x >> s) & 1) != 0) x = x ^ prim;
      end
      return acc;
   endfunction

   // alpha^e with alpha = x.
   function automatic int gf_alpha_pow(input int e, input int prim, input int s);
      int v;
      v = 1;
      for (int i = 0; i < e; i++) v = gf_mul(v, 2, prim, s);
      return v;
   endfunction

endpackage

// File: rtl/rs_gf_cmul.sv
module rs_gf_cmul #(
   parameter int S    = 8,
   parameter int PRIM = 'h11D,
   parameter int COEF = 1
) (
   input  logic [S-1:0] din,
   output logic [S-1:0] dout
);
   import rs_enc_pkg::*;

   generate
      if (COEF == 1) begin : g_pass
         assign dout = din;
      end else begin : g_matrix
         logic [S-1:0] col [S];
         for (genvar k = 0; k < S; k++) begin : g_col
            localparam logic [S-1:0] COLV = S'(gf_mul(COEF, 1 << k, PRIM, S));
            assign col[k] = din[k] ? COLV : '0;
         end
         always_comb begin
            dout = '0;
            for (int k = 0; k < S; k++) dout = dout ^ col[k];
         end
      end
   endgenerate

endmodule

// File: rtl/rs_par_lfsr.sv
module rs_par_lfsr #(
   parameter int S          = 8,
   parameter int NPAR       = 16,
   parameter int PRIM       = 'h11D,
   parameter int FIRST_ROOT = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         take,
   input  logic         restart,
   input  logic         shift,
   input  logic [S-1:0] din,
   output logic [S-1:0] top
);
   import rs_enc_pkg::*;

   typedef logic [NPAR-1:0][S-1:0] coef_t;

   // Coefficients of prod (x - alpha^(FIRST_ROOT+i)), monic term dropped.
   function automatic coef_t build_gen();
      int    g [NPAR+1];
      int    root;
      coef_t res;
      for (int j = 0; j <= NPAR; j++) g[j] = 0;
      g[0] = 1;
      for (int i = 0; i < NPAR; i++) begin
         root = gf_alpha_pow(FIRST_ROOT + i, PRIM, S);
         for (int j = i + 1; j >= 1; j--) g[j] = g[j-1] ^ gf_mul(g[j], root, PRIM, S);
         g[0] = gf_mul(g[0], root, PRIM, S);
      end
      for (int j = 0; j < NPAR; j++) res[j] = S'(g[j]);
      return res;
   endfunction

   localparam coef_t GCOEF = build_gen();

   logic [S-1:0] stage [NPAR];
   logic [S-1:0] prod  [NPAR];
   logic [S-1:0] prev  [NPAR];
   logic [S-1:0] fb;
   logic         step;

   assign step = take | shift;
   assign top  = stage[NPAR-1];
   assign fb   = take ? (din ^ (restart ? '0 : stage[NPAR-1])) : '0;

   generate
      for (genvar i = 0; i < NPAR; i++) begin : g_stage
         rs_gf_cmul #(
            .S    (S),
            .PRIM (PRIM),
            .COEF (int'(GCOEF[i]))
         ) u_cmul (
            .din  (fb),
            .dout (prod[i])
         );

         if (i == 0) begin : g_first
            assign prev[i] = '0;
         end else begin : g_rest
            assign prev[i] = (take && restart) ? '0 : stage[i-1];
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    stage[i] <= '0;
            else if (step) stage[i] <= prev[i] ^ prod[i];
         end
      end
   endgenerate

endmodule

// File: rtl/rs_enc_seq.sv
module rs_enc_seq #(
   parameter int NPAR = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_valid,
   input  logic in_eop,
   output logic in_ready,
   output logic take,
   output logic shift,
   output logic last_par
);
   import rs_enc_pkg::*;

   localparam int CW = (NPAR > 1) ? $clog2(NPAR) : 1;

   rs_phase_e      phase;
   logic [CW-1:0]  cnt;

   assign in_ready = (phase == PH_DATA);
   assign take     = in_valid & in_ready;
   assign shift    = (phase == PH_PARITY);
   assign last_par = shift && (cnt == CW'(NPAR - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_DATA;
         cnt   <= '0;
      end else if (take && in_eop) begin
         phase <= PH_PARITY;
         cnt   <= '0;
      end else if (shift) begin
         if (last_par) phase <= PH_DATA;
         cnt <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/rs_sys_encoder.sv
module rs_sys_encoder #(
   parameter int S          = 8,
   parameter int T          = 8,
   parameter int PRIM       = 'h11D,
   parameter int FIRST_ROOT = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   output logic         in_ready,
   input  logic [S-1:0] in_data,
   input  logic         in_sop,
   input  logic         in_eop,
   output logic         out_valid,
   output logic [S-1:0] out_data,
   output logic         out_sop,
   output logic         out_eop,
   output logic         out_parity
);
   localparam int NPAR = 2 * T;
   localparam int KMAX = (1 << S) - 1 - NPAR;

   generate
      if (S < 3 || S > 16) begin : g_bad_width
         $error("symbol width must lie in 3..16");
      end
      if (T < 1) begin : g_bad_t
         $error("T must be at least 1");
      end
      if ((PRIM >> S) != 1) begin : g_bad_prim
         $error("field polynomial must have degree S");
      end
      if (KMAX < 1) begin : g_bad_len
         $error("parity count leaves no room for message symbols");
      end
   endgenerate

   logic         take;
   logic         shift;
   logic         last_par;
   logic [S-1:0] par_top;

   rs_enc_seq #(
      .NPAR (NPAR)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_eop   (in_eop),
      .in_ready (in_ready),
      .take     (take),
      .shift    (shift),
      .last_par (last_par)
   );

   rs_par_lfsr #(
      .S          (S),
      .NPAR       (NPAR),
      .PRIM       (PRIM),
      .FIRST_ROOT (FIRST_ROOT)
   ) u_lfsr (
      .clk     (clk),
      .rst_n   (rst_n),
      .take    (take),
      .restart (in_sop),
      .shift   (shift),
      .din     (in_data),
      .top     (par_top)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_data   <= '0;
         out_sop    <= 1'b0;
         out_eop    <= 1'b0;
         out_parity <= 1'b0;
      end else begin
         out_valid  <= take | shift;
         out_sop    <= take & in_sop;
         out_eop    <= last_par;
         out_parity <= shift;
         if (take)       out_data <= in_data;
         else if (shift) out_data <= par_top;
      end
   end

endmodule

// File: rtl/rs_sys_encoder_chk.sv
module rs_sys_encoder_chk #(
   parameter int S    = 8,
   parameter int NPAR = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic         in_valid,
   input logic         in_ready,
   input logic [S-1:0] in_data,
   input logic         in_sop,
   input logic         in_eop,
   input logic         out_valid,
   input logic [S-1:0] out_data,
   input logic         out_sop,
   input logic         out_eop,
   input logic         out_parity
);
   int par_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) par_seen <= 0;
      else if (out_valid && out_parity) par_seen <= out_eop ? 0 : par_seen + 1;
   end

   assert_pass_through_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (out_valid && !out_parity && out_data == $past(in_data)));

   assert_sop_mirror_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (out_sop == $past(in_sop)));

   assert_parity_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_eop) |=> (out_valid && !out_parity) ##1 (out_valid && out_parity));

   assert_parity_unbroken_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_parity && !out_eop) |=> (out_valid && out_parity));

   assert_eop_on_parity_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_eop |-> (out_valid && out_parity && par_seen == NPAR - 1));

   assert_stall_in_parity_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_parity && !out_eop) |-> !in_ready);

   assert_ready_after_eop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_eop |-> in_ready);

   assert_idle_no_output_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready && !in_valid) |=> !out_valid);

endmodule

bind rs_sys_encoder rs_sys_encoder_chk #(
   .S    (S),
   .NPAR (2 * T)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_ready   (in_ready),
   .in_data    (in_data),
   .in_sop     (in_sop),
   .in_eop     (in_eop),
   .out_valid  (out_valid),
   .out_data   (out_data),
   .out_sop    (out_sop),
   .out_eop    (out_eop),
   .out_parity (out_parity)
);

// File: tb/rs_sys_encoder_tb_top.sv
module rs_sys_encoder_tb_top;

   localparam int NP1 = 16;
   localparam int NP2 = 6;

   localparam int TBL_N = 6;
   localparam int TBL_K    [TBL_N] = '{239, 1, 16, 50, 100, 2};
   localparam int TBL_SEED [TBL_N] = '{  1, 2,  3,  4,   5, 6};
   localparam int TBL_GAP  [TBL_N] = '{  0, 0,  3,  0,   7, 1};
   localparam int TBL_JUNK [TBL_N] = '{  0, 0,  0,  1,   1, 0};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic       sel = 1'b0;
   logic       d_valid = 1'b0;
   logic [7:0] d_data = '0;
   logic       d_sop = 1'b0;
   logic       d_eop = 1'b0;

   logic       rdy1, ov1, os1, oe1, op1;
   logic [7:0] od1;
   logic       rdy2, ov2, os2, oe2, op2;
   logic [7:0] od2;

   rs_sys_encoder dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(d_valid & !sel), .in_ready(rdy1),
      .in_data(d_data), .in_sop(d_sop), .in_eop(d_eop),
      .out_valid(ov1), .out_data(od1), .out_sop(os1), .out_eop(oe1), .out_parity(op1));

   rs_sys_encoder #(.S(8), .T(3), .PRIM('h187), .FIRST_ROOT(1)) dut2_i (
      .clk(clk), .rst_n(rst_n), .in_valid(d_valid & sel), .in_ready(rdy2),
      .in_data(d_data), .in_sop(d_sop), .in_eop(d_eop),
      .out_valid(ov2), .out_data(od2), .out_sop(os2), .out_eop(oe2), .out_parity(op2));

   wire       c_ready = sel ? rdy2 : rdy1;
   wire       c_valid = sel ? ov2 : ov1;
   wire [7:0] c_data  = sel ? od2 : od1;
   wire       c_sop   = sel ? os2 : os1;
   wire       c_eop   = sel ? oe2 : oe1;
   wire       c_par   = sel ? op2 : op1;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;

   always @(posedge clk) cyc <= cyc + 1;

   logic [7:0] cap_d [4096];
   logic       cap_s [4096];
   logic       cap_e [4096];
   logic       cap_p [4096];
   int         cap_c [4096];
   int         cap_wr = 0;
   int         cap_rd = 0;

   always @(negedge clk) begin
      if (c_valid && cap_wr < 4096) begin
         cap_d[cap_wr] = c_data;
         cap_s[cap_wr] = c_sop;
         cap_e[cap_wr] = c_eop;
         cap_p[cap_wr] = c_par;
         cap_c[cap_wr] = cyc;
         cap_wr = cap_wr + 1;
      end
   end

   logic [7:0] sent_d   [2][512];
   int         sent_acc [2][512];
   int         sent_k   [2];
   logic [7:0] par_buf  [16];
   logic [7:0] par_ref  [16];
   int         w_first_cyc = 0;
   int         w_last_cyc = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int np_cur();
      return sel ? NP2 : NP1;
   endfunction

   function automatic logic [7:0] dval(input int seed, input int j);
      return 8'((seed * 29 + j * 71 + ((j * j) >> 3) + 1) & 255);
   endfunction

   // Independent field model: repeated doubling of b times bits of a.
   function automatic int tb_gmul(input int a, input int b, input int prim);
      int r;
      int bb;
      r  = 0;
      bb = b;
      for (int i = 7; i >= 0; i--) begin
         r = r << 1;
         if (r > 255) r = r ^ prim;
         if (((a >> i) & 1) != 0) r = r ^ bb;
      end
      return r;
   endfunction

   task automatic send_word(input int slot, input int k, input int seed, input int zpre,
                            input int gap, input bit junk);
      sent_k[slot] = k;
      for (int j = 0; j < k; j++) begin
         if (gap > 0 && (j % gap) == gap - 1) begin
            d_valid = 1'b0;
            @(negedge clk);
         end
         d_valid = 1'b1;
         d_data  = (j < zpre) ? 8'h00 : dval(seed, j - zpre);
         d_sop   = (j == 0);
         d_eop   = (j == k - 1);
         while (!c_ready) @(negedge clk);
         @(negedge clk);
         sent_d[slot][j]   = d_data;
         sent_acc[slot][j] = cyc;
      end
      d_valid = 1'b0;
      d_sop   = 1'b0;
      d_eop   = 1'b0;
      if (junk) begin
         // R4: offer a bogus one-symbol word while parity is running
         d_valid = 1'b1;
         d_data  = 8'hA5;
         d_sop   = 1'b1;
         d_eop   = 1'b1;
         repeat (np_cur() - 1) @(negedge clk);
         d_valid = 1'b0;
         d_sop   = 1'b0;
         d_eop   = 1'b0;
      end
   endtask

   task automatic check_word(input int slot, input string synd_tag);
      int k, n, base, np, bad, first_bad_a, first_bad_e, prim, r0, root, acc;
      np = np_cur();
      k  = sent_k[slot];
      n  = k + np;
      while (cap_wr < cap_rd + n) @(negedge clk);
      base = cap_rd;

      bad = 0; first_bad_a = 0; first_bad_e = 0;
      for (int j = 0; j < k; j++) begin
         if (bad == 0 && (cap_d[base+j] !== sent_d[slot][j] || cap_p[base+j] !== 1'b0)) begin
            bad = 1; first_bad_a = int'(cap_d[base+j]); first_bad_e = int'(sent_d[slot][j]);
         end
      end
      chk(bad == 0, "R2 data copy", first_bad_a, first_bad_e);

      bad = 0;
      for (int j = 0; j < k; j++) if (cap_c[base+j] != sent_acc[slot][j]) bad++;
      chk(bad == 0, "R2 one-stage latency", bad, 0);

      bad = 0;
      for (int j = 0; j < n; j++) if (cap_s[base+j] !== (j == 0)) bad++;
      chk(bad == 0, "R2 start marker", bad, 0);

      bad = 0;
      for (int j = k; j < n; j++) begin
         if (cap_p[base+j] !== 1'b1) bad++;
         if (cap_c[base+j] != cap_c[base+k-1] + (j - k + 1)) bad++;
      end
      for (int j = 0; j < n; j++) if (cap_e[base+j] !== (j == n - 1)) bad++;
      chk(bad == 0, "R3 parity run", bad, 0);

      prim = sel ? 'h187 : 'h11D;
      r0   = sel ? 1 : 0;
      bad  = 0;
      for (int i = 0; i < np; i++) begin
         root = 1;
         for (int e = 0; e < r0 + i; e++) root = tb_gmul(root, 2, prim);
         acc = 0;
         for (int j = 0; j < n; j++) acc = tb_gmul(acc, root, prim) ^ int'(cap_d[base+j]);
         if (acc != 0) bad++;
      end
      chk(bad == 0, synd_tag, bad, 0);

      for (int j = 0; j < np; j++) par_buf[j] = cap_d[base+k+j];
      w_first_cyc = cap_c[base];
      w_last_cyc  = cap_c[base+n-1];
      cap_rd = base + n;
   endtask

   task automatic compare_parity(input string tag);
      int bad;
      bad = 0;
      for (int j = 0; j < np_cur(); j++) if (par_buf[j] !== par_ref[j]) bad++;
      chk(bad == 0, tag, bad, 0);
   endtask

   task automatic save_ref();
      for (int j = 0; j < 16; j++) par_ref[j] = par_buf[j];
   endtask

   task automatic expect_quiet(input string tag);
      repeat (np_cur() + 3) @(negedge clk);
      chk(cap_wr == cap_rd, tag, cap_wr - cap_rd, 0);
   endtask

   initial begin
      int lc;
      repeat (3) @(negedge clk);
      // R1: state while reset is held
      chk(rdy1 == 1'b1 && ov1 == 1'b0 && oe1 == 1'b0, "R1 during reset",
          int'({rdy1, ov1, oe1}), 4);
      rst_n = 1'b1;
      @(negedge clk);
      chk(rdy1 == 1'b1 && ov1 == 1'b0 && oe1 == 1'b0, "R1 after reset",
          int'({rdy1, ov1, oe1}), 4);

      // Table walk: lengths, idle gaps (R9) and offers during parity (R4)
      for (int t = 0; t < TBL_N; t++) begin
         send_word(0, TBL_K[t], TBL_SEED[t], 0, TBL_GAP[t], TBL_JUNK[t] != 0);
         check_word(0, "R5 syndromes");
         if (TBL_JUNK[t] != 0) expect_quiet("R4 nothing consumed");
         if (TBL_GAP[t] != 0) expect_quiet("R9 gaps add no output");
      end

      // R6: shortened word against its zero-prefixed twin
      send_word(0, 10, 9, 0, 0, 1'b0);
      check_word(0, "R5 syndromes");
      save_ref();
      send_word(0, 40, 9, 30, 0, 1'b0);
      check_word(0, "R5 syndromes");
      compare_parity("R6 zero prefix parity");

      // R7: restart over an unfinished word
      for (int j = 0; j < 5; j++) begin
         d_valid = 1'b1; d_data = dval(77, j); d_sop = (j == 0); d_eop = 1'b0;
         @(negedge clk);
      end
      d_valid = 1'b0; d_sop = 1'b0;
      while (cap_wr < cap_rd + 5) @(negedge clk);
      cap_rd = cap_rd + 5;
      send_word(0, 20, 12, 0, 0, 1'b0);
      check_word(0, "R5 syndromes");
      save_ref();
      send_word(0, 20, 12, 0, 0, 1'b0);
      check_word(0, "R5 syndromes");
      compare_parity("R7 restart parity");

      // R8: two words back to back
      send_word(0, 12, 21, 0, 0, 1'b0);
      send_word(1, 7, 22, 0, 0, 1'b0);
      check_word(0, "R5 syndromes");
      lc = w_last_cyc;
      check_word(1, "R5 syndromes");
      chk(w_first_cyc == lc + 1, "R8 no idle cycle", w_first_cyc, lc + 1);

      // R1: reset in the middle of a parity run
      send_word(0, 5, 31, 0, 0, 1'b0);
      repeat (2) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk(rdy1 == 1'b1 && ov1 == 1'b0 && oe1 == 1'b0, "R1 reset mid parity",
          int'({rdy1, ov1, oe1}), 4);
      rst_n = 1'b1;
      @(negedge clk);
      cap_rd = cap_wr;
      send_word(0, 30, 32, 0, 0, 1'b0);
      check_word(0, "R1 clean word after reset");

      // R10: second field polynomial and first root 1
      @(negedge clk);
      sel = 1'b1;
      @(negedge clk);
      cap_rd = cap_wr;
      send_word(0, 249, 41, 0, 0, 1'b0);
      check_word(0, "R10 syndromes full length");
      send_word(0, 3, 42, 0, 2, 1'b1);
      check_word(0, "R10 syndromes shortened");
      save_ref();
      send_word(0, 103, 42, 100, 0, 1'b0);
      check_word(0, "R10 syndromes zero prefix");
      compare_parity("R6 zero prefix second field");

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   always @(posedge clk) begin
      if (cyc > 100000) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule